// File: doc/BRIEF.md
# Parallel I/O port with latched pin events

This block is a small parallel I/O port for a chip's peripheral area. It offers up to 32 pins, each of which software can set as an input or an output, drive to a level, and watch for events. A simple word-oriented register bus reaches four registers: pin level and output latch, direction, interrupt enable and event capture. The pins arrive asynchronously. The block brings them through a two-stage synchronizer before anything looks at them.

A parameter fixed at build time picks the trigger type: rising edge, falling edge, either edge, or high level. In the three edge types, every qualifying transition sets a sticky capture bit. Software clears a capture bit by writing a one to it. One interrupt line is raised while any enabled capture bit is set. In level type the capture register stays empty, and the interrupt follows the enabled synchronized inputs directly. A second parameter sets the pin count. Register bits at and above that count are absent.

Top module: `pio_capture_unit`

## Requirements
- R1: Register selection uses the byte address `bus_addr`: 0x0 is pin data, 0x4 is direction, 0x8 is interrupt enable, 0xC is event capture. Any other address writes nothing and reads as zero. Read data is registered: `bus_rdata` takes the selected value at the clock edge that samples `bus_rd` high.
- R2: Register bits at positions PIN_COUNT and above always read as zero, and writes to them are ignored.
- R3: A direction bit of 1 makes its pin an output. `pin_oe` equals the direction register, and `pin_out` equals the output latch ANDed with the direction register.
- R4: Writing offset 0x0 loads the output latch. Reading offset 0x0 returns the pin inputs after a two-flop synchronizer, not the latch.
- R5: In edge types a capture bit is set when the synchronized input differs from its value one clock earlier in the chosen sense. TRIGGER encoding: 0 = rising (0 to 1), 1 = falling (1 to 0), 2 = both. The capture bit is set two clock edges after the input change is sampled.
- R6: Writing 1 to a capture bit clears it. Writing 0 leaves it unchanged.
- R7: If a new event and a clearing write hit the same capture bit in the same cycle, the bit stays set.
- R8: In edge types `irq` is high exactly while some bit of (capture AND enable) is set.
- R9: With TRIGGER = 3 (level high), `irq` is high exactly while some bit of (synchronized input AND enable) is set, with no latching, and the capture register reads as zero.
- R10: Reset clears the output latch, direction, enable, capture and read data. All pins start as inputs, and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 4 | Byte address of the register |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | PIN_COUNT | Asynchronous pin inputs |
| pin_out | output | PIN_COUNT | Output levels, zero where the pin is an input |
| pin_oe | output | PIN_COUNT | Output enable per pin |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds four copies that share one bus and one pin stimulus. The copies are a 12-pin both-edges port, a 32-pin rising-edge port, a 32-pin falling-edge port and an 8-pin level port. The narrow builds show that the absent upper bits read as zero and ignore writes. The full-width builds exercise bit 31. Running all four trigger types against the same transitions separates rising, falling, both-edge and level behaviour in one run. A directed step lines up a clearing write with a fresh edge in the same cycle.

// File: rtl/pio_pkg.sv
// Package: shared trigger type and register address constants for the
// parallel I/O port. Assumes a 32-bit data bus and byte addresses.
package pio_pkg;
    typedef enum logic [1:0] {
        TRIG_RISE  = 2'd0,
        TRIG_FALL  = 2'd1,
        TRIG_BOTH  = 2'd2,
        TRIG_LEVEL = 2'd3
    } trig_e;

    localparam int BUS_W  = 32;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] OFF_DATA = 4'h0;
    localparam logic [ADDR_W-1:0] OFF_DIR  = 4'h4;
    localparam logic [ADDR_W-1:0] OFF_MASK = 4'h8;
    localparam logic [ADDR_W-1:0] OFF_CAP  = 4'hC;
endpackage

// File: rtl/pio_sync.sv
// Module: two-flop synchronizer for the pin inputs, plus one more stage
// that holds the synchronized value from the previous clock.
// Assumes: the inputs are asynchronous, and each bit is synchronized on
// its own (no multi-bit coherence).
module pio_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_in,
    output logic [W-1:0] sync_now,
    output logic [W-1:0] sync_prev
);
    logic [W-1:0] meta_q;

    // Purpose: metastability stage, synchronized stage and history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q    <= '0;
            sync_now  <= '0;
            sync_prev <= '0;
        end else begin
            meta_q    <= raw_in;
            sync_now  <= meta_q;
            sync_prev <= sync_now;
        end
    end
endmodule

// File: rtl/pio_evt_detect.sv
// Module: per-pin event detector. The build-time trigger type picks the
// comparison. Level type produces no latched events.
// Assumes: sync_prev is sync_now delayed by one clock.
module pio_evt_detect #(
    parameter int             W       = 32,
    parameter pio_pkg::trig_e TRIGGER = pio_pkg::TRIG_BOTH
) (
    input  logic [W-1:0] sync_now,
    input  logic [W-1:0] sync_prev,
    output logic [W-1:0] evt
);
    generate
        if (TRIGGER == pio_pkg::TRIG_RISE) begin : g_rise
            // Purpose: flag 0-to-1 transitions.
            always_comb evt = sync_now & ~sync_prev;
        end else if (TRIGGER == pio_pkg::TRIG_FALL) begin : g_fall
            // Purpose: flag 1-to-0 transitions.
            always_comb evt = ~sync_now & sync_prev;
        end else if (TRIGGER == pio_pkg::TRIG_BOTH) begin : g_both
            // Purpose: flag any transition.
            always_comb evt = sync_now ^ sync_prev;
        end else begin : g_level
            // Purpose: level type latches nothing.
            always_comb evt = '0;
        end
    endgenerate
endmodule

// File: rtl/pio_regs.sv
// Module: the writable state of the port: output latch, direction,
// interrupt enable and the sticky event capture register.
// Assumes: at most one write per cycle, already decoded into a register
// select. In the capture register a same-cycle event beats a clear.
module pio_regs #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_data,
    input  logic         wr_dir,
    input  logic         wr_mask,
    input  logic         wr_cap,
    input  logic [W-1:0] wval,
    input  logic [W-1:0] evt,
    output logic [W-1:0] latch_q,
    output logic [W-1:0] dir_q,
    output logic [W-1:0] mask_q,
    output logic [W-1:0] cap_q
);
    logic [W-1:0] clr_bits;

    // Purpose: bits that a write-one-to-clear removes this cycle.
    always_comb clr_bits = wr_cap ? wval : '0;

    // Purpose: load the software registers and update the capture register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= '0;
            dir_q   <= '0;
            mask_q  <= '0;
            cap_q   <= '0;
        end else begin
            if (wr_data) latch_q <= wval;
            if (wr_dir)  dir_q   <= wval;
            if (wr_mask) mask_q  <= wval;
            cap_q <= (cap_q & ~clr_bits) | evt;
        end
    end
endmodule

// File: rtl/pio_capture_unit.sv
// Module: top of the parallel I/O port. Decodes the byte-addressed bus,
// registers read data, drives the pins and forms the interrupt.
// Assumes: PIN_COUNT is 1 to 32. The trigger type is fixed per build.
module pio_capture_unit #(
    parameter int             PIN_COUNT = 32,
    parameter pio_pkg::trig_e TRIGGER   = pio_pkg::TRIG_BOTH
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [pio_pkg::ADDR_W-1:0] bus_addr,
    input  logic                       bus_wr,
    input  logic [pio_pkg::BUS_W-1:0]  bus_wdata,
    input  logic                       bus_rd,
    output logic [pio_pkg::BUS_W-1:0]  bus_rdata,
    input  logic [PIN_COUNT-1:0]       pin_in,
    output logic [PIN_COUNT-1:0]       pin_out,
    output logic [PIN_COUNT-1:0]       pin_oe,
    output logic                       irq
);
    import pio_pkg::*;

    localparam int W = PIN_COUNT;

    logic [W-1:0] sync_w, prev_w, evt_w;
    logic [W-1:0] latch_q, dir_q, mask_q, cap_q;
    logic         sel_data, sel_dir, sel_mask, sel_cap;
    logic [BUS_W-1:0] rd_word;

    // Purpose: full address decode, so misaligned addresses select nothing.
    always_comb begin
        sel_data = (bus_addr == OFF_DATA);
        sel_dir  = (bus_addr == OFF_DIR);
        sel_mask = (bus_addr == OFF_MASK);
        sel_cap  = (bus_addr == OFF_CAP);
    end

    pio_sync #(.W(W)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .raw_in    (pin_in),
        .sync_now  (sync_w),
        .sync_prev (prev_w)
    );

    pio_evt_detect #(.W(W), .TRIGGER(TRIGGER)) u_evt (
        .sync_now  (sync_w),
        .sync_prev (prev_w),
        .evt       (evt_w)
    );

    pio_regs #(.W(W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_data (bus_wr && sel_data),
        .wr_dir  (bus_wr && sel_dir),
        .wr_mask (bus_wr && sel_mask),
        .wr_cap  (bus_wr && sel_cap),
        .wval    (bus_wdata[W-1:0]),
        .evt     (evt_w),
        .latch_q (latch_q),
        .dir_q   (dir_q),
        .mask_q  (mask_q),
        .cap_q   (cap_q)
    );

    // Purpose: pick the register to read, zero-extended to the bus width.
    always_comb begin
        rd_word = '0;
        if (sel_data)      rd_word[W-1:0] = sync_w;
        else if (sel_dir)  rd_word[W-1:0] = dir_q;
        else if (sel_mask) rd_word[W-1:0] = mask_q;
        else if (sel_cap)  rd_word[W-1:0] = cap_q;
    end

    // Purpose: register read data on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_word;
    end

    // Purpose: drive only the pins configured as outputs.
    always_comb begin
        pin_oe  = dir_q;
        pin_out = latch_q & dir_q;
    end

    generate
        if (TRIGGER == TRIG_LEVEL) begin : g_irq_level
            // Purpose: level type follows the enabled inputs directly.
            always_comb irq = |(sync_w & mask_q);
        end else begin : g_irq_edge
            // Purpose: edge types follow the enabled captured events.
            always_comb irq = |(cap_q & mask_q);
        end
    endgenerate
endmodule

// File: rtl/pio_capture_chk.sv
// Module: assertion checker for pio_capture_unit, attached with bind.
// Assumes: it sees the bus, the pins, and the detector and capture state.
module pio_capture_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic [3:0]   bus_addr,
    input logic         bus_wr,
    input logic [31:0]  bus_wdata,
    input logic [W-1:0] pin_oe,
    input logic         irq,
    input logic [W-1:0] evt,
    input logic [W-1:0] cap
);
    // R10: the first cycle out of reset has all pins as inputs and irq low.
    p_reset_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pin_oe == '0 && !irq));

    // R3: a direction write appears on the output enables next cycle.
    p_dir_to_oe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 4'hC - 4'h8) |=> (pin_oe == $past(bus_wdata[W-1:0])));

    // R6: a clearing write removes every written bit that saw no new event.
    p_w1c_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 4'hC) |=>
        ((cap & $past(bus_wdata[W-1:0]) & ~$past(evt)) == '0));

    // R7: a detected event is always in the capture register next cycle.
    p_event_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |=> ((cap & $past(evt)) == $past(evt)));

    // R5: a capture bit rises only where an event was detected.
    p_cap_needs_event_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((cap & ~$past(cap) & ~$past(evt)) == '0));
endmodule

bind pio_capture_unit pio_capture_chk #(.W(PIN_COUNT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .pin_oe    (pin_oe),
    .irq       (irq),
    .evt       (evt_w),
    .cap       (cap_q)
);

// File: tb/tb_pio_capture_unit.sv
`timescale 1ns/1ps
module tb_pio_capture_unit;
    import pio_pkg::*;

    localparam int    NI = 4;
    localparam int    NP [NI] = '{12, 32, 32, 8};
    localparam trig_e MD [NI] = '{TRIG_BOTH, TRIG_RISE, TRIG_FALL, TRIG_LEVEL};

    logic        clk = 0;
    logic        rst_n = 0;
    logic [3:0]  addr = '0;
    logic        wr = 0, rd = 0;
    logic [31:0] wdata = '0;
    logic [31:0] pins = '0;

    logic [31:0] rd0, rd1, rd2, rd3;
    logic        irq0, irq1, irq2, irq3;
    logic [11:0] po0, oe0;
    logic [31:0] po1, oe1, po2, oe2;
    logic [7:0]  po3, oe3;

    int n_chk = 0, n_fail = 0;
    logic [31:0] m_lat = '0, m_dir = '0, m_mask = '0, m_pins = '0;
    logic [31:0] m_cap [NI] = '{default: '0};
    logic [31:0] rb [NI];

    always #10 clk = ~clk;

    pio_capture_unit #(.PIN_COUNT(12), .TRIGGER(TRIG_BOTH)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr), .bus_wdata(wdata),
        .bus_rd(rd), .bus_rdata(rd0), .pin_in(pins[11:0]), .pin_out(po0),
        .pin_oe(oe0), .irq(irq0));
    pio_capture_unit #(.PIN_COUNT(32), .TRIGGER(TRIG_RISE)) dut_rise (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr), .bus_wdata(wdata),
        .bus_rd(rd), .bus_rdata(rd1), .pin_in(pins), .pin_out(po1),
        .pin_oe(oe1), .irq(irq1));
    pio_capture_unit #(.PIN_COUNT(32), .TRIGGER(TRIG_FALL)) dut_fall (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr), .bus_wdata(wdata),
        .bus_rd(rd), .bus_rdata(rd2), .pin_in(pins), .pin_out(po2),
        .pin_oe(oe2), .irq(irq2));
    pio_capture_unit #(.PIN_COUNT(8), .TRIGGER(TRIG_LEVEL)) dut_lvl (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr), .bus_wdata(wdata),
        .bus_rd(rd), .bus_rdata(rd3), .pin_in(pins[7:0]), .pin_out(po3),
        .pin_oe(oe3), .irq(irq3));

    function automatic logic [31:0] wm(int n);
        return (n >= 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 32'h1);
    endfunction

    function automatic logic [31:0] evf(trig_e m, logic [31:0] o, logic [31:0] n);
        case (m)
            TRIG_RISE: return ~o & n;
            TRIG_FALL: return o & ~n;
            TRIG_BOTH: return o ^ n;
            default:   return '0;
        endcase
    endfunction

    function automatic logic [31:0] get_rd(int i);
        case (i) 0: return rd0; 1: return rd1; 2: return rd2; default: return rd3; endcase
    endfunction
    function automatic logic [31:0] get_po(int i);
        case (i) 0: return {20'b0, po0}; 1: return po1; 2: return po2; default: return {24'b0, po3}; endcase
    endfunction
    function automatic logic [31:0] get_oe(int i);
        case (i) 0: return {20'b0, oe0}; 1: return oe1; 2: return oe2; default: return {24'b0, oe3}; endcase
    endfunction
    function automatic logic get_irq(int i);
        case (i) 0: return irq0; 1: return irq1; 2: return irq2; default: return irq3; endcase
    endfunction

    function automatic logic [31:0] exp_reg(int i, int a);
        case (a)
            0: return m_pins & wm(NP[i]);
            1: return m_dir & wm(NP[i]);
            2: return m_mask & wm(NP[i]);
            default: return (MD[i] == TRIG_LEVEL) ? 32'h0 : m_cap[i];
        endcase
    endfunction

    function automatic logic exp_irq(int i);
        if (MD[i] == TRIG_LEVEL) return |(m_pins & m_mask & wm(NP[i]));
        return |(m_cap[i] & m_mask & wm(NP[i]));
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_write(logic [3:0] a, logic [31:0] d);
        @(negedge clk); addr = a; wdata = d; wr = 1;
        @(negedge clk); wr = 0;
        case (a)
            4'h0: m_lat = d;
            4'h4: m_dir = d;
            4'h8: m_mask = d;
            4'hC: for (int i = 0; i < NI; i++) m_cap[i] &= ~d;
            default: ;
        endcase
    endtask

    task automatic bus_read(logic [3:0] a);
        @(negedge clk); addr = a; rd = 1;
        @(negedge clk); rd = 0;
        for (int i = 0; i < NI; i++) rb[i] = get_rd(i);
    endtask

    // Change the pins, then wait until the capture register has taken the event.
    task automatic set_pins(logic [31:0] n);
        logic [31:0] o = m_pins;
        @(negedge clk); pins = n;
        repeat (3) @(negedge clk);
        for (int i = 0; i < NI; i++) m_cap[i] |= evf(MD[i], o, n) & wm(NP[i]);
        m_pins = n;
    endtask

    task automatic check_all(string pfx);
        string tg [4] = '{"R4", "R3", "R2", "R5"};
        for (int a = 0; a < 4; a++) begin
            bus_read(4'(a * 4));
            for (int i = 0; i < NI; i++)
                check($sformatf("%s/%s inst%0d reg%0h", pfx, tg[a], i, a * 4), rb[i], exp_reg(i, a));
        end
        for (int i = 0; i < NI; i++) begin
            check($sformatf("%s/%s irq inst%0d", pfx, (MD[i] == TRIG_LEVEL) ? "R9" : "R8", i),
                  {31'b0, get_irq(i)}, {31'b0, exp_irq(i)});
            check($sformatf("%s/R3 pin_out inst%0d", pfx, i), get_po(i), m_lat & m_dir & wm(NP[i]));
            check($sformatf("%s/R3 pin_oe inst%0d", pfx, i), get_oe(i), m_dir & wm(NP[i]));
        end
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] w;
        void'($urandom(32'h5EED_0042));
        repeat (4) @(negedge clk);
        rst_n = 1;
        // R10: reset state.
        check_all("R10");

        // R2: upper bits absent; R3 drive only outputs.
        bus_write(4'h4, 32'hFFFF_FFFF);
        bus_write(4'h0, 32'hA5A5_A5A5);
        bus_write(4'h8, 32'hFFFF_FFFF);
        check_all("R2");

        // R1: misaligned address reads zero and writes nothing.
        bus_write(4'h6, 32'h0);
        bus_read(4'h6);
        for (int i = 0; i < NI; i++) check($sformatf("R1 misaligned inst%0d", i), rb[i], 32'h0);
        check_all("R1");

        // R5: rising then falling pattern on all pins.
        set_pins(32'h8000_0F0F);
        check_all("R5");
        set_pins(32'h0000_0F00);
        check_all("R5");

        // R6: clear only some bits; zeros leave others alone.
        bus_write(4'hC, 32'h0000_000F);
        check_all("R6");
        bus_write(4'hC, 32'hFFFF_FFFF);
        check_all("R6");

        // R9: level interrupt follows the input with no latching.
        bus_write(4'h8, 32'h0000_0001);
        set_pins(32'h0000_0001);
        check_all("R9");
        set_pins(32'h0000_0000);
        check_all("R9");

        // R7: event and clearing write to bit 0 in the same cycle.
        bus_write(4'hC, 32'hFFFF_FFFF);
        @(negedge clk); pins = 32'h0000_0001;
        @(negedge clk);
        @(negedge clk); addr = 4'hC; wdata = 32'h0000_0001; wr = 1;
        @(negedge clk); wr = 0;
        repeat (2) @(negedge clk);
        for (int i = 0; i < NI; i++)
            m_cap[i] = (m_cap[i] & ~32'h1) | (evf(MD[i], m_pins, 32'h1) & wm(NP[i]));
        m_pins = 32'h1;
        check_all("R7");

        // Random mix of register writes and pin changes.
        for (int k = 0; k < 120; k++) begin
            w = $urandom;
            case ($urandom % 5)
                0: bus_write(4'h0, w);
                1: bus_write(4'h4, w);
                2: bus_write(4'h8, w);
                3: bus_write(4'hC, w);
                default: set_pins(w);
            endcase
            if (k % 6 == 5) check_all("RND");
        end
        check_all("END");

        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule